// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a 32-bit virtual address into a 30-bit physical address in two stages. The upper bits of the virtual address pick one of eight segment entries. Each entry holds the word address of that segment's page table and the number of entries the table holds. The middle bits give the virtual page number. This number is compared against the segment's limit. When the number is in range, the block reads the page-table entry from memory. It then joins the returned physical page number to the unchanged page offset.

A requester offers an address while the block reports itself ready. The block then walks through a bound check, a memory fetch when the check passes, and a single-cycle response that carries either a physical address or a fault flag. Software fills the segment entries through a synchronous write port. Memory answers the fetch with an acknowledge pulse that carries the entry's data.

Top module: `seg_page_xlate`

## Requirements
- R1: The virtual address is split as segment index = bits 31:29, virtual page number = bits 28:12 and page offset = bits 11:0.
- R2: The segment table holds 8 entries, each a 30-bit page-table base and an 18-bit entry limit. A write updates entry `st_idx` at the clock edge where `st_we` is high. After reset every limit is zero, so every translation faults.
- R3: A virtual page number greater than or equal to the segment's limit produces a response with `resp_err` = 1. No memory read (`mem_req`) is issued for that request.
- R4: For an in-range page, `mem_addr` = page-table base + virtual page number, modulo 2^30. `mem_req` and `mem_addr` stay steady until the cycle in which `mem_ack` is seen.
- R5: A successful translation yields `resp_paddr` = {`mem_rdata`[17:0], page offset} with `resp_err` = 0. `resp_valid` is high for exactly one cycle per accepted request.
- R6: `req_ready` is high only when the block is idle. A `req_valid` while `req_ready` is low is ignored and has no effect on the response in progress.
- R7: Timing: the bound check takes the cycle after acceptance. A fault response appears in the next cycle. `mem_req` rises in the cycle after the check. The response appears in the cycle after `mem_ack`. The block is ready again in the cycle after the response.
- R8: `resp_paddr` is zero whenever no successful response is presented.
- R9: A limit of 2^17 admits every virtual page number up to 0x1FFFF. The entry address wraps at 2^30.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request offered |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| st_we | input | 1 | Segment entry write enable |
| st_idx | input | 3 | Segment entry index to write |
| st_base | input | 30 | Page-table base word address |
| st_bound | input | 18 | Number of entries in the page table |
| mem_req | output | 1 | Page-table entry read request |
| mem_addr | output | 30 | Word address of the page-table entry |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 18 | Physical page number returned |
| resp_valid | output | 1 | Response presented (one cycle) |
| resp_err | output | 1 | Translation fault |
| resp_paddr | output | 30 | Physical address |

## Verification
The assertions assume three things about the environment. Memory raises `mem_ack` only while `mem_req` is high. Every acknowledge is for the read in progress. The segment entry in use is not rewritten during its own bound check. The stimulus meets all three. A responder answers only an outstanding read, after a chosen delay of zero to three cycles. Table writes are issued only while no translation is in flight. Requests that arrive while the block is busy are raised and dropped before the block returns to idle.

// File: rtl/spx_pkg.sv
package spx_pkg;
  localparam int SPX_VA_W  = 32;
  localparam int SPX_SEG_W = 3;
  localparam int SPX_VPN_W = 17;
  localparam int SPX_OFF_W = 12;
  localparam int SPX_PPN_W = 18;
  localparam int SPX_MA_W  = 30;

  typedef enum logic [2:0] {
    XS_IDLE  = 3'd0,
    XS_CHECK = 3'd1,
    XS_FETCH = 3'd2,
    XS_DONE  = 3'd3,
    XS_ERROR = 3'd4
  } xlate_state_e;
endpackage

// File: rtl/spx_rst_sync.sv
module spx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/spx_seg_table.sv
module spx_seg_table #(
  parameter int NSEG  = 8,
  parameter int IDX_W = $clog2(NSEG),
  parameter int MA_W  = 30,
  parameter int BND_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [MA_W-1:0]  wbase,
  input  logic [BND_W-1:0] wbound,
  input  logic [IDX_W-1:0] ridx,
  output logic [MA_W-1:0]  rbase,
  output logic [BND_W-1:0] rbound
);
  logic [MA_W-1:0]  base_q  [NSEG];
  logic [BND_W-1:0] bound_q [NSEG];

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit_en;
    assign hit_en = we && (widx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_q[g]  <= '0;
        bound_q[g] <= '0;
      end else if (hit_en) begin
        base_q[g]  <= wbase;
        bound_q[g] <= wbound;
      end
    end
  end

  assign rbase  = base_q[ridx];
  assign rbound = bound_q[ridx];
endmodule

// File: rtl/spx_bound_chk.sv
module spx_bound_chk #(
  parameter int VPN_W = 17,
  parameter int MA_W  = 30,
  parameter int BND_W = VPN_W + 1
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [MA_W-1:0]  base,
  input  logic [BND_W-1:0] bound,
  output logic             fault,
  output logic [MA_W-1:0]  pte_addr
);
  logic [BND_W-1:0] vpn_ext;
  logic [MA_W-1:0]  vpn_wide;

  assign vpn_ext  = BND_W'(vpn);
  assign vpn_wide = MA_W'(vpn);
  assign fault    = (vpn_ext >= bound);
  assign pte_addr = base + vpn_wide;
endmodule

// File: rtl/spx_xlate_fsm.sv
module spx_xlate_fsm
  import spx_pkg::*;
#(
  parameter int VA_W  = 32,
  parameter int SEG_W = 3,
  parameter int VPN_W = 17,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18,
  parameter int MA_W  = 30,
  localparam int PA_W = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  output logic [SEG_W-1:0] seg_idx,
  output logic [VPN_W-1:0] vpn,
  input  logic             fault,
  input  logic [MA_W-1:0]  pte_addr,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PPN_W-1:0] mem_rdata,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [PA_W-1:0]  resp_paddr
);
  xlate_state_e     state_q, state_d;
  logic [VA_W-1:0]  va_q;
  logic [MA_W-1:0]  maddr_q;
  logic [PA_W-1:0]  pa_q;
  logic             va_en, maddr_en, pa_en;
  logic [OFF_W-1:0] off;

  assign seg_idx = va_q[VA_W-1 -: SEG_W];
  assign vpn     = va_q[OFF_W +: VPN_W];
  assign off     = va_q[OFF_W-1:0];

  assign va_en    = (state_q == XS_IDLE)  && req_valid;
  assign maddr_en = (state_q == XS_CHECK) && !fault;
  assign pa_en    = (state_q == XS_FETCH) && mem_ack;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      XS_IDLE:  if (req_valid) state_d = XS_CHECK;
      XS_CHECK: state_d = fault ? XS_ERROR : XS_FETCH;
      XS_FETCH: if (mem_ack) state_d = XS_DONE;
      XS_DONE:  state_d = XS_IDLE;
      XS_ERROR: state_d = XS_IDLE;
      default:  state_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= XS_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     va_q <= '0;
    else if (va_en) va_q <= req_vaddr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        maddr_q <= '0;
    else if (maddr_en) maddr_q <= pte_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pa_q <= '0;
    else if (pa_en) pa_q <= {mem_rdata, off};
  end

  assign req_ready  = (state_q == XS_IDLE);
  assign mem_req    = (state_q == XS_FETCH);
  assign mem_addr   = maddr_q;
  assign resp_valid = (state_q == XS_DONE) || (state_q == XS_ERROR);
  assign resp_err   = (state_q == XS_ERROR);
  assign resp_paddr = (state_q == XS_DONE) ? pa_q : '0;

  // R4: outstanding read keeps request and address steady
  a_r4_hold_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  // R5: response lasts one cycle
  a_r5_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);

  // R5: acknowledged read gives a clean response next cycle
  a_r5_ack_to_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (resp_valid && !resp_err));

  // R3: a fault is never preceded by a memory read
  a_r3_err_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> !$past(mem_req));

  // R6: accepted request drops ready
  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

  // R8: no address leaks on a fault
  a_r8_err_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    resp_err |-> (resp_paddr == '0));
endmodule

// File: rtl/seg_page_xlate.sv
module seg_page_xlate
  import spx_pkg::*;
#(
  parameter int VA_W  = SPX_VA_W,
  parameter int SEG_W = SPX_SEG_W,
  parameter int VPN_W = SPX_VPN_W,
  parameter int OFF_W = SPX_OFF_W,
  parameter int PPN_W = SPX_PPN_W,
  parameter int MA_W  = SPX_MA_W,
  localparam int NSEG  = 1 << SEG_W,
  localparam int BND_W = VPN_W + 1,
  localparam int PA_W  = PPN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VA_W-1:0]  req_vaddr,
  output logic             req_ready,
  input  logic             st_we,
  input  logic [SEG_W-1:0] st_idx,
  input  logic [MA_W-1:0]  st_base,
  input  logic [BND_W-1:0] st_bound,
  output logic             mem_req,
  output logic [MA_W-1:0]  mem_addr,
  input  logic             mem_ack,
  input  logic [PPN_W-1:0] mem_rdata,
  output logic             resp_valid,
  output logic             resp_err,
  output logic [PA_W-1:0]  resp_paddr
);
  logic             rst_sn;
  logic [SEG_W-1:0] seg_idx;
  logic [VPN_W-1:0] vpn;
  logic [MA_W-1:0]  seg_base;
  logic [BND_W-1:0] seg_bound;
  logic             fault;
  logic [MA_W-1:0]  pte_addr;

  spx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn)
  );

  spx_seg_table #(.NSEG(NSEG), .IDX_W(SEG_W), .MA_W(MA_W), .BND_W(BND_W)) u_tab (
    .clk(clk), .rst_n(rst_sn), .we(st_we), .widx(st_idx), .wbase(st_base),
    .wbound(st_bound), .ridx(seg_idx), .rbase(seg_base), .rbound(seg_bound)
  );

  spx_bound_chk #(.VPN_W(VPN_W), .MA_W(MA_W), .BND_W(BND_W)) u_chk (
    .vpn(vpn), .base(seg_base), .bound(seg_bound),
    .fault(fault), .pte_addr(pte_addr)
  );

  spx_xlate_fsm #(.VA_W(VA_W), .SEG_W(SEG_W), .VPN_W(VPN_W), .OFF_W(OFF_W),
                  .PPN_W(PPN_W), .MA_W(MA_W)) u_fsm (
    .clk(clk), .rst_n(rst_sn), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .seg_idx(seg_idx), .vpn(vpn), .fault(fault),
    .pte_addr(pte_addr), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_paddr(resp_paddr)
  );
endmodule

// File: tb/sim_seg_page_xlate.sv
module sim_seg_page_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        req_ready;
  logic        st_we = 1'b0;
  logic [2:0]  st_idx = '0;
  logic [29:0] st_base = '0;
  logic [17:0] st_bound = '0;
  logic        mem_req;
  logic [29:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [17:0] mem_rdata = '0;
  logic        resp_valid, resp_err;
  logic [29:0] resp_paddr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int ack_dly = 0;
  int dly_cnt = 0;
  bit model_on = 1'b0;

  always #4 clk = ~clk;

  seg_page_xlate u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_ready(req_ready), .st_we(st_we), .st_idx(st_idx), .st_base(st_base),
    .st_bound(st_bound), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
    .resp_err(resp_err), .resp_paddr(resp_paddr)
  );

  logic [17:0] pt_mem [256];

  // behavioural reference
  int          m_phase;
  logic [31:0] m_va;
  logic [29:0] m_maddr;
  logic [29:0] m_pa;
  logic [29:0] m_base  [8];
  logic [17:0] m_bound [8];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase <= 0; m_va <= '0; m_maddr <= '0; m_pa <= '0;
      for (int i = 0; i < 8; i++) begin m_base[i] <= '0; m_bound[i] <= '0; end
    end else begin
      if (st_we) begin m_base[st_idx] <= st_base; m_bound[st_idx] <= st_bound; end
      case (m_phase)
        0: if (req_valid) begin m_va <= req_vaddr; m_phase <= 1; end
        1: begin
          if ({1'b0, m_va[28:12]} >= m_bound[m_va[31:29]]) m_phase <= 4;
          else begin
            m_maddr <= 30'(m_base[m_va[31:29]] + {13'b0, m_va[28:12]});
            m_phase <= 2;
          end
        end
        2: if (mem_ack) begin m_pa <= {mem_rdata, m_va[11:0]}; m_phase <= 3; end
        default: m_phase <= 0;
      endcase
    end
  end

  // per-cycle comparison, then memory responder
  always @(negedge clk) begin
    if (model_on) begin
      chk(req_ready == (m_phase == 0), "R6 ready", 32'(req_ready), 32'(m_phase == 0));
      chk(mem_req == (m_phase == 2), "R3 R7 mem_req", 32'(mem_req), 32'(m_phase == 2));
      if (m_phase == 2) chk(mem_addr == m_maddr, "R4 mem_addr", 32'(mem_addr), 32'(m_maddr));
      chk(resp_valid == (m_phase == 3 || m_phase == 4), "R5 resp_valid",
          32'(resp_valid), 32'(m_phase == 3 || m_phase == 4));
      chk(resp_err == (m_phase == 4), "R3 resp_err", 32'(resp_err), 32'(m_phase == 4));
      chk(resp_paddr == ((m_phase == 3) ? m_pa : 30'd0), "R8 resp_paddr",
          32'(resp_paddr), 32'((m_phase == 3) ? m_pa : 30'd0));
    end
    if (mem_req && !mem_ack) begin
      if (dly_cnt >= ack_dly) begin
        mem_ack = 1'b1;
        mem_rdata = pt_mem[mem_addr[7:0]];
        dly_cnt = 0;
      end else dly_cnt++;
    end else begin
      mem_ack = 1'b0;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic wr_seg(input int idx, input logic [29:0] b, input logic [17:0] lim);
    @(negedge clk);
    st_we = 1'b1; st_idx = 3'(idx); st_base = b; st_bound = lim;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic xlate(input int seg, input int vp, input int off, input int dly,
                       input bit busy_poke, input string req);
    logic [31:0] va;
    logic [29:0] ea;
    bit          fault;
    va = {3'(seg), 17'(vp), 12'(off)};
    fault = ({1'b0, 17'(vp)} >= m_bound[seg]);
    ea = 30'(m_base[seg] + 30'(vp));
    ack_dly = dly; dly_cnt = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_vaddr = va;
    @(negedge clk);
    if (busy_poke) begin
      req_vaddr = ~va;
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (!resp_valid) @(negedge clk);
    chk(resp_err == fault, req, 32'(resp_err), 32'(fault));
    if (!fault)
      chk(resp_paddr == {pt_mem[ea[7:0]], 12'(off)}, req, 32'(resp_paddr),
          32'({pt_mem[ea[7:0]], 12'(off)}));
  endtask

  initial begin
    for (int i = 0; i < 256; i++) pt_mem[i] = 18'((i * 1237 + 91) ^ (i << 9));
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_req == 1'b0, "R6 reset state",
        {29'b0, req_ready, resp_valid, mem_req}, 32'h4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_on = 1'b1;

    // R2: all limits zero after reset
    xlate(3, 0, 12'h123, 0, 0, "R2 zero limit faults");
    xlate(0, 5, 0, 0, 0, "R2 zero limit faults");

    wr_seg(0, 30'h10, 18'd4);
    wr_seg(1, 30'h3FFF_FFF0, 18'h20000);
    wr_seg(2, 30'h80, 18'd1);
    wr_seg(7, 30'h20, 18'h100);

    xlate(0, 3, 12'hABC, 0, 0, "R1 R5 last entry in range");
    xlate(0, 4, 12'h001, 0, 0, "R3 vpn equals limit");
    xlate(0, 9000, 12'h001, 0, 0, "R3 vpn beyond limit");
    xlate(1, 17'h1FFFF, 12'hFFF, 2, 0, "R9 max limit wraps");
    xlate(2, 0, 12'h800, 3, 0, "R4 slow ack");
    xlate(2, 1, 12'h800, 1, 0, "R3 limit one");
    xlate(7, 17'h50, 12'h7E5, 1, 1, "R6 busy request ignored");
    xlate(7, 17'hFF, 12'h000, 0, 0, "R7 back to back");
    xlate(7, 17'h00, 12'hFFF, 2, 0, "R7 back to back");
    // R2: rewrite and observe new limit
    wr_seg(7, 30'h40, 18'd2);
    xlate(7, 17'h50, 12'h010, 0, 0, "R2 rewritten limit");
    xlate(7, 17'h1, 12'h010, 3, 0, "R2 rewritten base");
    repeat (4) @(negedge clk);
    chk(resp_valid == 1'b0, "R5 no extra response", 32'(resp_valid), 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule